// File: doc/BRIEF.md
# Double-Buffered Point-of-View Register Bank

This block receives a camera description for a beam-racing renderer over a three-wire, write-only serial link and presents it as six parallel fields to the pixel pipeline. The serial pins are asynchronous to the system clock. They are brought in through synchronizers and sampled on detected edges of the serial clock. The serial clock is expected to run at no more than about a fifth of the system clock.

A finished transfer does not reach the renderer straight away. It is parked in a shadow copy, and the live fields change only on the pulse that marks the start of vertical blanking. A frame being drawn therefore never sees a half-updated camera. A host may write at any moment, write several times per frame, or abandon a transfer part-way. Two demo inputs stand in for a host: they nudge the player position once per frame, and they throw away anything waiting in the shadow copy.

There is no data stream with flow control here. The serial pins, the blanking strobe and the demo inputs are plain control pins, and no back-pressure exists: a write that arrives while another is pending simply replaces it.

Top module: `pov_spi_regbank`

## Requirements
- R1: While `rst_n` is low, the live fields take these values: X position 0x0B00 (5.5), Y position 0x1340 (9.625), direction X 0x000, direction Y 0x200 (1.0), plane X 0x700 (-0.5), plane Y 0x000.
- R2: A transfer is the bits sent on `spi_sdi` while `spi_cs_n` is low, one bit per rising edge of `spi_sck`, first bit most significant. Bits 73..59 are the X position and 58..44 the Y position, both unsigned with 9 fraction bits. Bits 43..33, 32..22, 21..11 and 10..0 are direction X, direction Y, plane X and plane Y, each two's complement with 9 fraction bits.
- R3: The live fields change only in the cycle after a cycle in which `vblank_start` is high. A completed transfer without that strobe leaves them as they were.
- R4: A transfer with fewer than 74 bits is dropped. A word that was already pending stays pending and is committed at the next `vblank_start`.
- R5: A transfer with more than 74 bits is dropped in the same way.
- R6: When several transfers complete before one `vblank_start`, the last one completed is committed.
- R7: A cycle with `demo_inc_x` or `demo_inc_y` high discards any pending word, even if the demo input falls again before `vblank_start`.
- R8: At `vblank_start`, each demo input that is high adds 1 (1/512) to its position field, wrapping from 0x7FFF to 0x0000. In that frame no word is committed.
- R9: A transfer whose end (rise of `spi_cs_n`) is recognised in the same cycle as `vblank_start` is committed at that strobe.
- R10: A `vblank_start` with no word pending and no demo input high leaves every live field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs_n | input | 1 | Serial select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock, bit sampled on its rising edge |
| spi_sdi | input | 1 | Serial data in |
| vblank_start | input | 1 | One-cycle strobe at the start of vertical blanking |
| demo_inc_x | input | 1 | Demo mode: step X position each frame |
| demo_inc_y | input | 1 | Demo mode: step Y position each frame |
| view_pos_x | output | 15 | Live X position, unsigned 6.9 |
| view_pos_y | output | 15 | Live Y position, unsigned 6.9 |
| view_dir_x | output | 11 | Live direction X, signed 2.9 |
| view_dir_y | output | 11 | Live direction Y, signed 2.9 |
| view_plane_x | output | 11 | Live view-plane X, signed 2.9 |
| view_plane_y | output | 11 | Live view-plane Y, signed 2.9 |

## Verification
Two events can fall on the same clock edge: the end of a transfer, which loads the shadow copy, and the blanking strobe, which empties it into the live fields. The bench raises select and then times the strobe so that it lands exactly where the end of the transfer is recognised. It then requires the new word on the live outputs right after that strobe, not a frame later. A second collision, a demo input held high across the strobe while a word is pending, is judged by requiring a position step and no commit.

// File: rtl/pov_pkg.sv
package pov_pkg;
  localparam int POS_W  = 15;
  localparam int VEC_W  = 11;
  localparam int WORD_W = 2 * POS_W + 4 * VEC_W;
  localparam int CNT_W  = $clog2(WORD_W + 2);

  // Field order matches transfer order: first field received sits at the MSB.
  typedef struct packed {
    logic [POS_W-1:0] pos_x;
    logic [POS_W-1:0] pos_y;
    logic [VEC_W-1:0] dir_x;
    logic [VEC_W-1:0] dir_y;
    logic [VEC_W-1:0] plane_x;
    logic [VEC_W-1:0] plane_y;
  } view_t;

  localparam view_t VIEW_RESET = '{
    pos_x:   POS_W'(2816),
    pos_y:   POS_W'(4928),
    dir_x:   VEC_W'(0),
    dir_y:   VEC_W'(512),
    plane_x: VEC_W'(1792),
    plane_y: VEC_W'(0)
  };
endpackage

// File: rtl/pov_sync.sv
module pov_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pov_spi_rx.sv
module pov_spi_rx
  import pov_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  output logic              word_done,
  output logic [WORD_W-1:0] word
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  logic              sck_q, cs_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;

  wire sck_rise = sck_s & ~sck_q;
  wire cs_rise  = cs_n_s & ~cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
      bit_cnt   <= '0;
      shreg     <= '0;
      word_done <= 1'b0;
    end else begin
      sck_q     <= sck_s;
      cs_q      <= cs_n_s;
      word_done <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
        if (cs_rise) word_done <= (bit_cnt == FULL);
      end else if (sck_rise) begin
        shreg <= {shreg[WORD_W-2:0], sdi_s};
        if (bit_cnt != OVER) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign word = shreg;
endmodule

// File: rtl/pov_commit.sv
module pov_commit
  import pov_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word,
  input  logic              frame_start,
  input  logic              demo_x,
  input  logic              demo_y,
  output view_t             live,
  output logic              pend_valid
);
  view_t pend;
  wire   demo_any = demo_x | demo_y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live       <= VIEW_RESET;
      pend       <= VIEW_RESET;
      pend_valid <= 1'b0;
    end else begin
      if (demo_any) begin
        pend_valid <= 1'b0;
      end else if (word_done) begin
        pend       <= view_t'(word);
        pend_valid <= 1'b1;
      end
      if (frame_start) begin
        if (demo_any) begin
          if (demo_x) live.pos_x <= live.pos_x + 1'b1;
          if (demo_y) live.pos_y <= live.pos_y + 1'b1;
        end else if (word_done) begin
          live       <= view_t'(word);
          pend_valid <= 1'b0;
        end else if (pend_valid) begin
          live       <= pend;
          pend_valid <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pov_spi_regbank.sv
module pov_spi_regbank
  import pov_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sck,
  input  logic             spi_sdi,
  input  logic             vblank_start,
  input  logic             demo_inc_x,
  input  logic             demo_inc_y,
  output logic [POS_W-1:0] view_pos_x,
  output logic [POS_W-1:0] view_pos_y,
  output logic [VEC_W-1:0] view_dir_x,
  output logic [VEC_W-1:0] view_dir_y,
  output logic [VEC_W-1:0] view_plane_x,
  output logic [VEC_W-1:0] view_plane_y
);
  logic [2:0]        pins_s;
  logic              word_done;
  logic [WORD_W-1:0] word;
  logic              pend_valid;
  view_t             live;

  pov_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_sck, spi_sdi}),
    .q     (pins_s)
  );

  pov_spi_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (pins_s[2]),
    .sck_s     (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .word_done (word_done),
    .word      (word)
  );

  pov_commit u_commit (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_done   (word_done),
    .word        (word),
    .frame_start (vblank_start),
    .demo_x      (demo_inc_x),
    .demo_y      (demo_inc_y),
    .live        (live),
    .pend_valid  (pend_valid)
  );

  assign view_pos_x   = live.pos_x;
  assign view_pos_y   = live.pos_y;
  assign view_dir_x   = live.dir_x;
  assign view_dir_y   = live.dir_y;
  assign view_plane_x = live.plane_x;
  assign view_plane_y = live.plane_y;
endmodule

// File: rtl/pov_spi_regbank_chk.sv
module pov_spi_regbank_chk
  import pov_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             vblank_start,
  input logic             demo_inc_x,
  input logic             demo_inc_y,
  input logic             word_done,
  input logic             pend_valid,
  input logic [POS_W-1:0] view_pos_x,
  input logic [POS_W-1:0] view_pos_y,
  input logic [VEC_W-1:0] view_dir_x,
  input logic [VEC_W-1:0] view_plane_y
);
  assert_live_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank_start |=> ($stable(view_pos_x) && $stable(view_pos_y) &&
                       $stable(view_dir_x) && $stable(view_plane_y)));

  assert_demo_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (demo_inc_x || demo_inc_y) |=> !pend_valid);

  assert_demo_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_start && demo_inc_x) |=> view_pos_x == $past(view_pos_x) + 1'b1);

  assert_pending_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_valid) |-> $past(word_done));

  assert_idle_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_start && !pend_valid && !word_done && !demo_inc_x && !demo_inc_y)
      |=> ($stable(view_pos_x) && $stable(view_pos_y)));
endmodule

bind pov_spi_regbank pov_spi_regbank_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vblank_start (vblank_start),
  .demo_inc_x   (demo_inc_x),
  .demo_inc_y   (demo_inc_y),
  .word_done    (word_done),
  .pend_valid   (pend_valid),
  .view_pos_x   (view_pos_x),
  .view_pos_y   (view_pos_y),
  .view_dir_x   (view_dir_x),
  .view_plane_y (view_plane_y)
);

// File: tb/pov_spi_regbank_tb.sv
module pov_spi_regbank_tb;
  import pov_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic vbl = 1'b0, dx = 1'b0, dy = 1'b0;
  logic [POS_W-1:0] px, py;
  logic [VEC_W-1:0] fx, fy, vx, vy;
  int checks = 0, fails = 0;
  view_t exp_v;

  always #10 clk = ~clk;

  pov_spi_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_sdi(sdi),
    .vblank_start(vbl), .demo_inc_x(dx), .demo_inc_y(dy),
    .view_pos_x(px), .view_pos_y(py), .view_dir_x(fx), .view_dir_y(fy),
    .view_plane_x(vx), .view_plane_y(vy)
  );

  // Row: {bit count[6:0], demo x, demo y, word[73:0]}
  localparam int NROW = 6;
  localparam logic [82:0] VECS [NROW] = '{
    {7'd74, 2'b00, 15'h1234, 15'h0456, 11'h123, 11'h7FF, 11'h400, 11'h001},
    {7'd73, 2'b00, 15'h7FFF, 15'h7FFF, 11'h7FF, 11'h7FF, 11'h7FF, 11'h7FF},
    {7'd75, 2'b00, 15'h0001, 15'h0002, 11'h003, 11'h004, 11'h005, 11'h006},
    {7'd74, 2'b10, 15'h2AAA, 15'h5555, 11'h2AA, 11'h555, 11'h0F0, 11'h70F},
    {7'd74, 2'b01, 15'h0F0F, 15'h70F0, 11'h111, 11'h222, 11'h333, 11'h444},
    {7'd74, 2'b00, 15'h6001, 15'h0003, 11'h600, 11'h1FF, 11'h201, 11'h7C0}
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_view(input string req, input view_t e);
    view_t a;
    a = '{pos_x: px, pos_y: py, dir_x: fx, dir_y: fy, plane_x: vx, plane_y: vy};
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h_%h_%h_%h_%h_%h expected=%h_%h_%h_%h_%h_%h", req,
               a.pos_x, a.pos_y, a.dir_x, a.dir_y, a.plane_x, a.plane_y,
               e.pos_x, e.pos_y, e.dir_x, e.dir_y, e.plane_x, e.plane_y);
    end
  endtask

  // Sends nbits bits MSB first; bits past the word are zeros.
  task automatic spi_send(input logic [WORD_W-1:0] w, input int nbits, input bit hit_vbl);
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < WORD_W) ? w[WORD_W-1-i] : 1'b0;
      tick(3);
      sck = 1'b1;
      tick(3);
      sck = 1'b0;
    end
    tick(3);
    cs_n = 1'b1;
    if (hit_vbl) begin
      // select rise: two sync stages, edge detect, done register -> used at 4th edge
      repeat (3) @(posedge clk);
      @(negedge clk) vbl = 1'b1;
      @(negedge clk) vbl = 1'b0;
      tick(1);
    end else begin
      tick(8);
    end
  endtask

  task automatic frame();
    @(negedge clk) vbl = 1'b1;
    @(negedge clk) vbl = 1'b0;
    tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    view_t w;
    tick(4);
    exp_v = VIEW_RESET;
    check_view("R1 reset values", exp_v);
    rst_n = 1'b1;
    tick(2);
    check_view("R1 values after reset release", exp_v);

    // Table walk: R2 layout, R4 short, R5 long, R7/R8 demo
    for (int r = 0; r < NROW; r++) begin
      logic [82:0] row;
      int nb;
      row = VECS[r];
      nb  = int'(row[82:76]);
      spi_send(row[73:0], nb, 1'b0);
      if (row[75] || row[74]) begin
        dx = row[75];
        dy = row[74];
        tick(2);
        frame();
        dx = 1'b0;
        dy = 1'b0;
        tick(1);
        if (row[75]) exp_v.pos_x = exp_v.pos_x + 1'b1;
        if (row[74]) exp_v.pos_y = exp_v.pos_y + 1'b1;
      end else begin
        frame();
        if (nb == WORD_W) exp_v = view_t'(row[73:0]);
      end
      check_view($sformatf("R2 R4 R5 R7 R8 table row %0d", r), exp_v);
    end

    // R3: completed write stays hidden until the strobe
    w = '{15'h0101, 15'h0202, 11'h033, 11'h044, 11'h055, 11'h066};
    spi_send(w, 74, 1'b0);
    tick(20);
    check_view("R3 no commit without vblank", exp_v);
    frame();
    exp_v = w;
    check_view("R3 commit at vblank", exp_v);

    // R6: last completed wins
    spi_send({15'h0AAA, 15'h0BBB, 11'h0CC, 11'h0DD, 11'h0EE, 11'h0FF}, 74, 1'b0);
    w = '{15'h1111, 15'h2222, 11'h333, 11'h444, 11'h555, 11'h666};
    spi_send(w, 74, 1'b0);
    frame();
    exp_v = w;
    check_view("R6 last write wins", exp_v);

    // R4: partial transfer keeps earlier pending word
    w = '{15'h3003, 15'h4004, 11'h505, 11'h606, 11'h707, 11'h008};
    spi_send(w, 74, 1'b0);
    spi_send({15'h7777, 15'h7777, 11'h777, 11'h777, 11'h777, 11'h777}, 40, 1'b0);
    frame();
    exp_v = w;
    check_view("R4 pending kept after partial", exp_v);

    // R10: idle frame
    frame();
    check_view("R10 idle vblank no change", exp_v);

    // R8: wrap of both positions
    w = '{15'h7FFF, 15'h7FFF, 11'h001, 11'h002, 11'h003, 11'h004};
    spi_send(w, 74, 1'b0);
    frame();
    exp_v = w;
    check_view("R2 all-ones positions committed", exp_v);
    dx = 1'b1;
    dy = 1'b1;
    tick(1);
    frame();
    dx = 1'b0;
    dy = 1'b0;
    exp_v.pos_x = '0;
    exp_v.pos_y = '0;
    check_view("R8 wrap to zero", exp_v);

    // R7: short demo pulse before vblank still discards
    spi_send({15'h1357, 15'h2468, 11'h135, 11'h246, 11'h357, 11'h468}, 74, 1'b0);
    dy = 1'b1;
    tick(3);
    dy = 1'b0;
    tick(3);
    frame();
    check_view("R7 demo pulse discards pending", exp_v);

    // R9: transfer end and vblank on the same edge
    w = '{15'h0C0C, 15'h0D0D, 11'h0E0, 11'h0F0, 11'h1A0, 11'h1B0};
    spi_send(w, 74, 1'b1);
    exp_v = w;
    check_view("R9 same-cycle completion commits", exp_v);
    frame();
    check_view("R9 nothing left pending", exp_v);

    // R1: reset in mid-operation restores defaults
    spi_send({15'h5555, 15'h5555, 11'h555, 11'h555, 11'h555, 11'h555}, 74, 1'b0);
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    frame();
    exp_v = VIEW_RESET;
    check_view("R1 reset clears live and pending", exp_v);

    summary();
  end
endmodule